// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the power-mode state machine of a small processor subsystem. From run mode it moves into one of three depths of low power. The depth depends on two mode bits (deep request and standby select) and on which entry strobe fires: a sleep-now strobe, a wait-for-event strobe, or an interrupt-return strobe that counts only when the return-to-sleep bit is set. Each depth has its own set of wake sources. Each also drives the CPU clock enable, the core-domain clock enable, the oscillator enable, the regulator low-power request and the core power-off request in its own way.

Peripheral clocks are gated per bit. In run mode a peripheral's clock follows its run enable. In the shallow sleep depth the clock also needs the peripheral's sleep enable. In the deeper depths every peripheral clock is off. Leaving the middle depth is done in two steps: the oscillator comes back first, and the core clocks follow after a programmable settling count. Leaving the deepest depth does not resume. It gives a one-cycle restart indication and then returns to run. The wake pin passes through a two-flop synchroniser, and only a 0-to-1 transition wakes the block.

Top module: `pwr_mode_seq`

## Requirements
- R1: From run, with `deep_req`=0, a high `sleep_now` or `wait_evt`, or `isr_return` while `sleep_on_ret`=1, enters sleep on the sampling edge, so `cpu_clk_en` is 0 in the following cycle. `isr_return` with `sleep_on_ret`=0 is ignored. If `sleep_now` and `wait_evt` are high together, the sleep is the interrupt-woken kind.
- R2: In sleep, `cpu_clk_en`=0 while `core_clk_en`=1, `osc_en`=1, `reg_lp_req`=0 and `core_off_req`=0.
- R3: A sleep entered by `sleep_now` or `isr_return` ends on `irq` and ignores `evt`. A sleep entered by `wait_evt` alone ends on `evt` and ignores `irq`. `cpu_clk_en` returns to 1 in the cycle after the edge that samples the wake input.
- R4: From run, with `deep_req`=1 and `stby_sel`=0, any entry strobe (gated as in R1) enters stop.
- R5: In stop, `cpu_clk_en`, `core_clk_en`, `osc_en` and every bit of `periph_clk_en` are 0.
- R6: In stop, `reg_lp_req` equals the value of `lp_reg_sel` sampled at the entry edge. Later changes to `lp_reg_sel` have no effect.
- R7: From run, with `deep_req`=1 and `stby_sel`=1, any entry strobe enters standby. In standby `core_off_req`=1 and all clock and oscillator enables are 0.
- R8: Standby ends only on a wake-pin rise, `rtc_alarm_a`, `rtc_alarm_b`, `rtc_tick`, `rtc_tamper`, `rtc_stamp`, `ext_reset` or `wdt_reset`. `irq`, `evt` and `ext_line` do not end it.
- R9: Bit i of `periph_clk_en` equals `run_en[i]` in run and `run_en[i] & sleep_en[i]` in sleep.
- R10: Leaving standby gives exactly one cycle with `restart`=1 and run outputs, and then run. `restart` is 0 at all other times.
- R11: `wake_pin` is synchronised through two flops and only a rise wakes standby. A rise driven before edge e0 gives `restart`=1 after edge e2. A pin held high does not wake.
- R12: Stop ends when any bit of `ext_line & ext_line_en` is 1. `osc_en` goes to 1 in the next cycle while `core_clk_en` stays 0 for `stab_cnt`+1 cycles. Then the run outputs return. Lines whose enable bit is 0 are ignored.
- R13: During and after reset the block is in run: `cpu_clk_en`=1, `core_clk_en`=1, `osc_en`=1, `reg_lp_req`=0, `core_off_req`=0, `restart`=0, `periph_clk_en`=`run_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_now | input | 1 | Sleep-instruction strobe |
| wait_evt | input | 1 | Wait-for-event strobe |
| isr_return | input | 1 | Interrupt-return strobe |
| deep_req | input | 1 | Selects stop or standby instead of sleep |
| stby_sel | input | 1 | With deep_req: 1 standby, 0 stop |
| lp_reg_sel | input | 1 | Regulator low-power choice for stop |
| sleep_on_ret | input | 1 | Lets interrupt return enter low power |
| irq | input | 1 | Pending interrupt |
| evt | input | 1 | Wake event |
| ext_line | input | N_LINE | External-line wake inputs |
| ext_line_en | input | N_LINE | Per-line wake enables |
| wake_pin | input | 1 | Asynchronous wake pin |
| rtc_alarm_a | input | 1 | RTC alarm A |
| rtc_alarm_b | input | 1 | RTC alarm B |
| rtc_tick | input | 1 | RTC periodic wakeup |
| rtc_tamper | input | 1 | RTC tamper event |
| rtc_stamp | input | 1 | RTC timestamp event |
| ext_reset | input | 1 | External reset request |
| wdt_reset | input | 1 | Watchdog reset request |
| run_en | input | N_PERIPH | Run-mode peripheral clock enables |
| sleep_en | input | N_PERIPH | Sleep-mode peripheral clock enables |
| stab_cnt | input | STAB_W | Oscillator settling count |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | N_PERIPH | Gated peripheral clock enables |
| core_clk_en | output | 1 | Core-domain clock enable |
| osc_en | output | 1 | High-speed oscillator enable |
| reg_lp_req | output | 1 | Regulator low-power request |
| core_off_req | output | 1 | Core power-off request |
| restart | output | 1 | One-cycle restart after standby |

## Verification
The assertions check on every cycle that each depth's output pattern holds: sleep stops only the CPU, stop shuts all clocks and the oscillator, and standby requests power-off. They also check that the core clock is never enabled without the oscillator, that `restart` can only follow a standby cycle, that peripheral gating tracks both enable vectors, and that an event-woken sleep stays put while `evt` is low. Other behaviour needs the bench's scenarios. This covers the exact latency of the wake-pin synchroniser, that a pin held high does not wake, the length of the settling window for given counts, the sampling of the regulator choice at entry, and that each standby wake source and each ignored input behaves as stated.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PS_RUN      = 3'd0,
    PS_SLP_IRQ  = 3'd1,
    PS_SLP_EVT  = 3'd2,
    PS_STOP     = 3'd3,
    PS_STOP_OSC = 3'd4,
    PS_STBY     = 3'd5,
    PS_RESTART  = 3'd6
  } pwr_state_t;

  // Depth chosen at the entry edge from the mode bits and the strobe kind.
  function automatic pwr_state_t entry_target(input logic deep,
                                              input logic stby,
                                              input logic evt_only);
    if (!deep)     return evt_only ? PS_SLP_EVT : PS_SLP_IRQ;
    else if (stby) return PS_STBY;
    else           return PS_STOP;
  endfunction

  // Entry qualifier: an interrupt return counts only when return-to-sleep is set.
  function automatic logic entry_fire(input logic now, input logic wfe,
                                      input logic ret, input logic on_ret);
    return now | wfe | (ret & on_ret);
  endfunction

  // Sleep wakes on event only when wait-for-event was the sole strobe.
  function automatic logic evt_only_entry(input logic now, input logic wfe,
                                          input logic ret, input logic on_ret);
    return wfe & ~now & ~(ret & on_ret);
  endfunction

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[LAST-1:0], pin_i};
  end

  // Rise seen at the synchronised output, against its one-cycle-old copy.
  assign rise_o = sh_q[LAST-1] & ~sh_q[LAST];
endmodule

// File: rtl/pwr_periph_gate.sv
module pwr_periph_gate #(
  parameter int N_PERIPH = 8
) (
  input  logic                run_mode_i,
  input  logic                slp_mode_i,
  input  logic [N_PERIPH-1:0] run_en_i,
  input  logic [N_PERIPH-1:0] slp_en_i,
  output logic [N_PERIPH-1:0] en_o
);
  for (genvar i = 0; i < N_PERIPH; i++) begin : g_bit
    assign en_o[i] = run_en_i[i] & (run_mode_i | (slp_mode_i & slp_en_i[i]));
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int STAB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_i,
  input  logic              evt_only_i,
  input  logic              deep_i,
  input  logic              stby_i,
  input  logic              lp_sel_i,
  input  logic              irq_i,
  input  logic              evt_i,
  input  logic              line_hit_i,
  input  logic              stby_hit_i,
  input  logic [STAB_W-1:0] stab_i,
  output pwr_state_t        state_o,
  output logic              lp_q_o
);
  pwr_state_t        state_q, state_d;
  logic [STAB_W-1:0] cnt_q;
  logic              stab_done;

  assign stab_done = (cnt_q == stab_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN:      if (entry_i)    state_d = entry_target(deep_i, stby_i, evt_only_i);
      PS_SLP_IRQ:  if (irq_i)      state_d = PS_RUN;
      PS_SLP_EVT:  if (evt_i)      state_d = PS_RUN;
      PS_STOP:     if (line_hit_i) state_d = PS_STOP_OSC;
      PS_STOP_OSC: if (stab_done)  state_d = PS_RUN;
      PS_STBY:     if (stby_hit_i) state_d = PS_RESTART;
      PS_RESTART:                  state_d = PS_RUN;
      default:                     state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RUN;
      cnt_q   <= '0;
      lp_q_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == PS_STOP_OSC && state_d == PS_STOP_OSC) cnt_q <= cnt_q + 1'b1;
      else                                                  cnt_q <= '0;
      if (state_q == PS_RUN && state_d == PS_STOP) lp_q_o <= lp_sel_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int N_PERIPH = 8,
  parameter int N_LINE   = 4,
  parameter int STAB_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_now,
  input  logic                wait_evt,
  input  logic                isr_return,
  input  logic                deep_req,
  input  logic                stby_sel,
  input  logic                lp_reg_sel,
  input  logic                sleep_on_ret,
  input  logic                irq,
  input  logic                evt,
  input  logic [N_LINE-1:0]   ext_line,
  input  logic [N_LINE-1:0]   ext_line_en,
  input  logic                wake_pin,
  input  logic                rtc_alarm_a,
  input  logic                rtc_alarm_b,
  input  logic                rtc_tick,
  input  logic                rtc_tamper,
  input  logic                rtc_stamp,
  input  logic                ext_reset,
  input  logic                wdt_reset,
  input  logic [N_PERIPH-1:0] run_en,
  input  logic [N_PERIPH-1:0] sleep_en,
  input  logic [STAB_W-1:0]   stab_cnt,
  output logic                cpu_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                core_clk_en,
  output logic                osc_en,
  output logic                reg_lp_req,
  output logic                core_off_req,
  output logic                restart
);
  // Named internal events, visible to the bound checker.
  pwr_state_t state;
  logic       lp_q;
  logic       entry_hit;
  logic       evt_only;
  logic       wake_rise;
  logic       line_hit;
  logic       stby_hit;
  logic       run_mode;
  logic       slp_mode;

  assign entry_hit = entry_fire(sleep_now, wait_evt, isr_return, sleep_on_ret);
  assign evt_only  = evt_only_entry(sleep_now, wait_evt, isr_return, sleep_on_ret);
  assign line_hit  = |(ext_line & ext_line_en);
  assign stby_hit  = wake_rise | rtc_alarm_a | rtc_alarm_b | rtc_tick |
                     rtc_tamper | rtc_stamp | ext_reset | wdt_reset;

  pwr_wake_sync #(.SYNC_STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (wake_pin),
    .rise_o (wake_rise)
  );

  pwr_mode_fsm #(.STAB_W(STAB_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .entry_i    (entry_hit),
    .evt_only_i (evt_only),
    .deep_i     (deep_req),
    .stby_i     (stby_sel),
    .lp_sel_i   (lp_reg_sel),
    .irq_i      (irq),
    .evt_i      (evt),
    .line_hit_i (line_hit),
    .stby_hit_i (stby_hit),
    .stab_i     (stab_cnt),
    .state_o    (state),
    .lp_q_o     (lp_q)
  );

  always_comb begin
    cpu_clk_en   = 1'b1;
    core_clk_en  = 1'b1;
    osc_en       = 1'b1;
    reg_lp_req   = 1'b0;
    core_off_req = 1'b0;
    restart      = 1'b0;
    run_mode     = 1'b1;
    slp_mode     = 1'b0;
    unique case (state)
      PS_SLP_IRQ, PS_SLP_EVT: begin
        cpu_clk_en = 1'b0;
        run_mode   = 1'b0;
        slp_mode   = 1'b1;
      end
      PS_STOP: begin
        cpu_clk_en  = 1'b0;
        core_clk_en = 1'b0;
        osc_en      = 1'b0;
        reg_lp_req  = lp_q;
        run_mode    = 1'b0;
      end
      PS_STOP_OSC: begin
        cpu_clk_en  = 1'b0;
        core_clk_en = 1'b0;
        run_mode    = 1'b0;
      end
      PS_STBY: begin
        cpu_clk_en   = 1'b0;
        core_clk_en  = 1'b0;
        osc_en       = 1'b0;
        core_off_req = 1'b1;
        run_mode     = 1'b0;
      end
      PS_RESTART: restart = 1'b1;
      default: ;
    endcase
  end

  pwr_periph_gate #(.N_PERIPH(N_PERIPH)) u_gate (
    .run_mode_i (run_mode),
    .slp_mode_i (slp_mode),
    .run_en_i   (run_en),
    .slp_en_i   (sleep_en),
    .en_o       (periph_clk_en)
  );
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk
  import pwr_mode_pkg::*;
#(
  parameter int N_PERIPH = 8
) (
  input logic                clk,
  input logic                rst_n,
  input pwr_state_t          state,
  input logic                evt,
  input logic                cpu_clk_en,
  input logic                core_clk_en,
  input logic                osc_en,
  input logic                reg_lp_req,
  input logic                core_off_req,
  input logic                restart,
  input logic [N_PERIPH-1:0] run_en,
  input logic [N_PERIPH-1:0] sleep_en,
  input logic [N_PERIPH-1:0] periph_clk_en
);
  AST_SLEEP_CPU_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_SLP_IRQ || state == PS_SLP_EVT) |->
      (!cpu_clk_en && core_clk_en && osc_en && !reg_lp_req && !core_off_req)); // R2

  AST_EVT_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_SLP_EVT && !evt) |=> (state == PS_SLP_EVT)); // R3

  AST_STOP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_STOP) |-> (!cpu_clk_en && !core_clk_en && !osc_en && periph_clk_en == '0)); // R5

  AST_STBY_POWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_STBY) |-> (core_off_req && !osc_en && !core_clk_en && !cpu_clk_en)); // R7

  AST_SLEEP_GATING: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && core_clk_en) |-> (periph_clk_en == (run_en & sleep_en))); // R9

  AST_RESTART_AFTER_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restart) |-> $past(core_off_req)); // R10

  AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart); // R10

  AST_OSC_BEFORE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> osc_en); // R12
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.N_PERIPH(N_PERIPH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .state         (state),
  .evt           (evt),
  .cpu_clk_en    (cpu_clk_en),
  .core_clk_en   (core_clk_en),
  .osc_en        (osc_en),
  .reg_lp_req    (reg_lp_req),
  .core_off_req  (core_off_req),
  .restart       (restart),
  .run_en        (run_en),
  .sleep_en      (sleep_en),
  .periph_clk_en (periph_clk_en)
);

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int NL = 4;
  localparam int SW = 8;
  localparam int WATCHDOG_CYCLES = 20000;

  // {run_en, sleep_en, expected periph_clk_en in sleep}
  localparam logic [23:0] GATE_VEC [6] = '{
    {8'hFF, 8'h0F, 8'h0F},
    {8'hA5, 8'hFF, 8'hA5},
    {8'h3C, 8'h00, 8'h00},
    {8'hF0, 8'h3C, 8'h30},
    {8'h81, 8'h81, 8'h81},
    {8'h00, 8'hFF, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_now = 0, wait_evt = 0, isr_return = 0;
  logic deep_req = 0, stby_sel = 0, lp_reg_sel = 0, sleep_on_ret = 0;
  logic irq = 0, evt = 0;
  logic [NL-1:0] ext_line = '0, ext_line_en = '0;
  logic wake_pin = 0;
  logic rtc_alarm_a = 0, rtc_alarm_b = 0, rtc_tick = 0, rtc_tamper = 0, rtc_stamp = 0;
  logic ext_reset = 0, wdt_reset = 0;
  logic [NP-1:0] run_en = 8'hFF, sleep_en = 8'h00;
  logic [SW-1:0] stab_cnt = '0;
  logic cpu_clk_en, core_clk_en, osc_en, reg_lp_req, core_off_req, restart;
  logic [NP-1:0] periph_clk_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  pwr_mode_seq #(.N_PERIPH(NP), .N_LINE(NL), .STAB_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_now(sleep_now), .wait_evt(wait_evt),
    .isr_return(isr_return), .deep_req(deep_req), .stby_sel(stby_sel),
    .lp_reg_sel(lp_reg_sel), .sleep_on_ret(sleep_on_ret), .irq(irq), .evt(evt),
    .ext_line(ext_line), .ext_line_en(ext_line_en), .wake_pin(wake_pin),
    .rtc_alarm_a(rtc_alarm_a), .rtc_alarm_b(rtc_alarm_b), .rtc_tick(rtc_tick),
    .rtc_tamper(rtc_tamper), .rtc_stamp(rtc_stamp), .ext_reset(ext_reset),
    .wdt_reset(wdt_reset), .run_en(run_en), .sleep_en(sleep_en), .stab_cnt(stab_cnt),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .core_clk_en(core_clk_en),
    .osc_en(osc_en), .reg_lp_req(reg_lp_req), .core_off_req(core_off_req),
    .restart(restart)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: the edge, then settle to the falling edge for sampling and driving.
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic set_src(input int k, input logic v);
    case (k)
      0: rtc_alarm_a = v;
      1: rtc_alarm_b = v;
      2: rtc_tick    = v;
      3: rtc_tamper  = v;
      4: rtc_stamp   = v;
      5: ext_reset   = v;
      default: wdt_reset = v;
    endcase
  endtask

  task automatic enter_with_sleep_now();
    sleep_now = 1; step(); sleep_now = 0;
  endtask

  initial begin
    @(negedge clk);
    // R13: reset state
    chk("R13 cpu_clk_en in reset", cpu_clk_en, 1);
    chk("R13 core/osc in reset", {core_clk_en, osc_en}, 2'b11);
    chk("R13 lp/off/restart in reset", {reg_lp_req, core_off_req, restart}, 3'b000);
    chk("R13 periph follows run_en", periph_clk_en, 8'hFF);
    step(2);
    rst_n = 1;
    step();
    chk("R13 run after reset", {cpu_clk_en, core_clk_en, osc_en, core_off_req}, 4'b1110);

    // R9/R1/R3: table of gating vectors walked through sleep and back
    foreach (GATE_VEC[v]) begin
      run_en = GATE_VEC[v][23:16];
      sleep_en = GATE_VEC[v][15:8];
      step();
      chk("R9 run gating", periph_clk_en, GATE_VEC[v][23:16]);
      enter_with_sleep_now();
      chk("R1 sleep entered", cpu_clk_en, 0);
      chk("R9 sleep gating", periph_clk_en, GATE_VEC[v][7:0]);
      irq = 1; step(); irq = 0;
      chk("R3 irq wakes sleep", cpu_clk_en, 1);
      chk("R9 run gating restored", periph_clk_en, GATE_VEC[v][23:16]);
    end
    run_en = 8'hFF; sleep_en = 8'h00;

    // R1: interrupt return without return-to-sleep is ignored
    isr_return = 1; step(); isr_return = 0;
    chk("R1 isr_return ignored without sleep_on_ret", cpu_clk_en, 1);
    sleep_on_ret = 1;
    isr_return = 1; step(); isr_return = 0;
    sleep_on_ret = 0;
    chk("R1 isr_return enters sleep", cpu_clk_en, 0);
    chk("R2 sleep keeps core/osc", {core_clk_en, osc_en, reg_lp_req, core_off_req}, 4'b1100);
    evt = 1; step(); evt = 0;
    chk("R3 evt ignored in irq sleep", cpu_clk_en, 0);
    irq = 1; step(); irq = 0;
    chk("R3 irq ends isr-entered sleep", cpu_clk_en, 1);

    // R3: wait-for-event sleep
    wait_evt = 1; step(); wait_evt = 0;
    chk("R1 wait_evt enters sleep", cpu_clk_en, 0);
    irq = 1; step(3); irq = 0;
    chk("R3 irq ignored in event sleep", cpu_clk_en, 0);
    evt = 1; step(); evt = 0;
    chk("R3 evt ends event sleep", cpu_clk_en, 1);

    // R1: both strobes give the interrupt-woken sleep
    sleep_now = 1; wait_evt = 1; step(); sleep_now = 0; wait_evt = 0;
    irq = 1; step(); irq = 0;
    chk("R1 both strobes wake on irq", cpu_clk_en, 1);

    // R4/R5/R6/R12: stop with low-power regulator and settling count 3
    deep_req = 1; stby_sel = 0; lp_reg_sel = 1; stab_cnt = 8'd3;
    enter_with_sleep_now();
    lp_reg_sel = 0;
    chk("R4 stop entered", {cpu_clk_en, core_off_req}, 2'b00);
    chk("R5 stop clocks off", {core_clk_en, osc_en}, 2'b00);
    chk("R5 stop periph off", periph_clk_en, 8'h00);
    chk("R6 regulator low power latched", reg_lp_req, 1);
    ext_line = 4'b0010; ext_line_en = 4'b0001; irq = 1; evt = 1;
    step(3);
    irq = 0; evt = 0;
    chk("R12 disabled line and irq ignored", {osc_en, core_clk_en}, 2'b00);
    chk("R6 regulator unchanged by later select", reg_lp_req, 1);
    ext_line_en = 4'b0010;
    step();
    ext_line = '0; ext_line_en = '0;
    chk("R12 oscillator first", {osc_en, core_clk_en, cpu_clk_en}, 3'b100);
    step(3);
    chk("R12 core still off during settling", core_clk_en, 0);
    step();
    chk("R12 run restored after settling", {core_clk_en, cpu_clk_en, osc_en}, 3'b111);
    chk("R12 periph back", periph_clk_en, 8'hFF);

    // R6/R12: stop with regulator on, zero settling count, entry by wait_evt
    stab_cnt = 8'd0;
    wait_evt = 1; step(); wait_evt = 0;
    chk("R6 regulator on in stop", {reg_lp_req, osc_en}, 2'b00);
    ext_line = 4'b1000; ext_line_en = 4'b1000; step();
    ext_line = '0; ext_line_en = '0;
    chk("R12 osc with zero count", {osc_en, core_clk_en}, 2'b10);
    step();
    chk("R12 run after zero count", {core_clk_en, cpu_clk_en}, 2'b11);

    // R7/R8/R11: standby, pin held high does not wake
    stby_sel = 1;
    wake_pin = 1; step(4);
    sleep_on_ret = 1; isr_return = 1; step(); isr_return = 0; sleep_on_ret = 0;
    chk("R7 standby power off", core_off_req, 1);
    chk("R7 standby clocks off", {cpu_clk_en, core_clk_en, osc_en, periph_clk_en}, 11'h0);
    irq = 1; evt = 1; ext_line = 4'hF; ext_line_en = 4'hF;
    step(5);
    irq = 0; evt = 0; ext_line = '0; ext_line_en = '0;
    chk("R8 irq/evt/line ignored in standby", core_off_req, 1);
    chk("R11 level-high pin does not wake", restart, 0);
    wake_pin = 0; step(3);
    chk("R11 falling pin does not wake", core_off_req, 1);
    wake_pin = 1;
    step(2);
    chk("R11 synchroniser latency", {core_off_req, restart}, 2'b10);
    step();
    chk("R10 restart after pin rise", {restart, core_off_req, cpu_clk_en}, 3'b101);
    step();
    chk("R10 restart single cycle", {restart, cpu_clk_en, core_clk_en}, 3'b011);
    wake_pin = 0;

    // R8/R10: each remaining standby wake source
    for (int k = 0; k < 7; k++) begin
      enter_with_sleep_now();
      chk("R7 standby re-entered", core_off_req, 1);
      set_src(k, 1); step(); set_src(k, 0);
      chk("R8 source wakes standby", {restart, core_off_req}, 2'b10);
      step();
      chk("R10 back to run", {restart, cpu_clk_en}, 2'b01);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG_CYCLES);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG_CYCLES);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule